// File: doc/BRIEF.md
# Transmit FIR Emphasis Encoder

This block shapes a serial transmit stream before it reaches a line driver. It accepts one data bit per unit interval (one clock cycle) and produces a signed drive-amplitude code each interval. The code is a weighted sum of four bits taken from a short delay line. One bit is the look-ahead (pre-cursor) bit, one is the current (main) bit, and two are earlier (post-cursor) bits. Each bit counts as +1 when it is a logic 1 and as -1 when it is a logic 0.

Each tap has an unsigned magnitude. The main tap always adds and the first post-cursor tap always subtracts. The pre-cursor tap and the second post-cursor tap each carry a sign bit that can be programmed. With these settings the coefficients can either lift transitions above repeated bits (pre-emphasis) or pull repeated bits below transitions (de-emphasis). Coefficients are written into a shadow set and become active together on a commit strobe, so no interval ever mixes old and new taps. The summed value is clamped to the signed range of the output code. A downstream DAC model consumes that code.

Top module: `tx_fir_emph`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `drv_code` is 0 and `drv_valid` is 0. Reset clears the shadow and active coefficients to magnitude 0 with sign bit 0.
- R2: Let b(n) be the bit on `bit_in` at clock edge n. The code registered at edge n+1 is built from these bits: pre-cursor = b(n), main = b(n-1), first post = b(n-2), second post = b(n-3). Bit 1 counts as +1 and bit 0 as -1.
- R3: The main tap always adds its term and the first post-cursor tap always subtracts its term. `cfg_neg` written to either of these taps has no effect.
- R4: `cfg_sel` selects the tap that a write reaches: 0 is the pre-cursor tap, 1 the main tap, 2 the first post tap and 3 the second post tap. Each magnitude is held on its own.
- R5: A write (`cfg_we`) changes only the shadow set. The output keeps using the active set until a commit.
- R6: When `cfg_commit` is sampled high at edge c, all four taps switch together. The code registered at edge c is still from the old set, and the code registered at edge c+1 uses the new set.
- R7: When a write and a commit fall on the same edge, the commit takes the shadow set as it stood before that write.
- R8: The sum is saturated to the range [-2^(OUT_W-1), 2^(OUT_W-1)-1]. With OUT_W=6, a sum of 62 gives 31 and a sum of -62 gives -32.
- R9: `drv_valid` first goes high at the fifth edge after reset is released and then stays high until the next reset.
- R10: When the pre-cursor and both post-cursor magnitudes are 0, the code equals the main magnitude times the mapped main bit.
- R11: When the sign bit of the pre-cursor or second post-cursor tap is 1, that tap subtracts its term. The same coefficient set gives a larger code on a transition (24+8=32) than on a repeated bit (24-8=16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one unit interval per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit for this interval |
| cfg_we | input | 1 | Write strobe into the shadow coefficient set |
| cfg_sel | input | 2 | Tap select: 0 pre, 1 main, 2 post1, 3 post2 |
| cfg_mag | input | COEF_W | Unsigned tap magnitude |
| cfg_neg | input | 1 | Sign bit; 1 subtracts (used for pre and post2 only) |
| cfg_commit | input | 1 | Copies the shadow set into the active set |
| drv_code | output | OUT_W | Signed, saturated drive amplitude code |
| drv_valid | output | 1 | High once the delay line has been filled |

## Verification
The hardest case to bring about is the exact edge at which a commit takes effect, especially when a write lands on the same edge as the commit. In that case the output must show neither the new write nor a mix of the two sets. The bench holds the data stream constant so that only the coefficients can move the code. It samples the code on the commit edge and on the edge after it, and it stages a write and a commit together to prove that the write waits for the following commit. The saturation limits cannot be reached with the default widths. A second, narrower instance fed with the same stimulus drives its sums past both rails.

// File: rtl/tx_fir_pkg.sv
package tx_fir_pkg;

  localparam int NUM_TAPS  = 4;
  localparam int TAP_SEL_W = 2;

  // Tap positions; the index is the slot in the delay line (0 = newest bit).
  typedef enum logic [TAP_SEL_W-1:0] {
    TAP_PRE   = 2'd0,
    TAP_MAIN  = 2'd1,
    TAP_POST1 = 2'd2,
    TAP_POST2 = 2'd3
  } tap_e;

  // Taps whose sign is chosen at run time.
  function automatic bit tap_has_sign(input int idx);
    return (idx == int'(TAP_PRE)) || (idx == int'(TAP_POST2));
  endfunction

  // Fixed sign convention for the remaining taps: 1 means subtract.
  function automatic bit tap_fixed_neg(input int idx);
    return (idx == int'(TAP_POST1));
  endfunction

endpackage

// File: rtl/tx_fir_tapline.sv
module tx_fir_tapline #(
  parameter int DEPTH = 4,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [DEPTH-1:0] taps,
  output logic             filled
);

  logic [FILL_W-1:0] fill_cnt;

  // Slot 0 holds the newest bit; higher slots hold older bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      taps     <= '0;
      fill_cnt <= '0;
    end else begin
      taps <= {taps[DEPTH-2:0], bit_in};
      if (fill_cnt != FILL_W'(DEPTH)) begin
        fill_cnt <= fill_cnt + 1'b1;
      end
    end
  end

  assign filled = (fill_cnt == FILL_W'(DEPTH));

endmodule

// File: rtl/tx_fir_coef_bank.sv
module tx_fir_coef_bank
  import tx_fir_pkg::*;
#(
  parameter int COEF_W = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                we,
  input  logic [TAP_SEL_W-1:0]                sel,
  input  logic [COEF_W-1:0]                   mag,
  input  logic                                neg,
  input  logic                                commit,
  output logic [NUM_TAPS-1:0][COEF_W-1:0]     act_mag,
  output logic [NUM_TAPS-1:0]                 act_neg
);

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam logic [TAP_SEL_W-1:0] IDX = TAP_SEL_W'(g);

    logic              hit;
    logic [COEF_W-1:0] sh_mag_q;
    logic [COEF_W-1:0] act_mag_q;

    assign hit = we && (sel == IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_mag_q <= '0;
      end else if (hit) begin
        sh_mag_q <= mag;
      end
    end

    // The commit reads the shadow value as registered before this edge.
    always_ff @(posedge clk) begin
      if (rst) begin
        act_mag_q <= '0;
      end else if (commit) begin
        act_mag_q <= sh_mag_q;
      end
    end

    assign act_mag[g] = act_mag_q;

    if (tap_has_sign(g)) begin : g_prog_sign
      logic sh_neg_q;
      logic act_neg_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          sh_neg_q <= 1'b0;
        end else if (hit) begin
          sh_neg_q <= neg;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          act_neg_q <= 1'b0;
        end else if (commit) begin
          act_neg_q <= sh_neg_q;
        end
      end

      assign act_neg[g] = act_neg_q;
    end else begin : g_fixed_sign
      assign act_neg[g] = tap_fixed_neg(g);
    end
  end

endmodule

// File: rtl/tx_fir_sum.sv
module tx_fir_sum
  import tx_fir_pkg::*;
#(
  parameter int COEF_W = 5,
  parameter int OUT_W  = 8,
  localparam int SUM_W = COEF_W + 3,
  localparam int CMP_W = ((SUM_W > OUT_W) ? SUM_W : OUT_W) + 1
) (
  input  logic [NUM_TAPS-1:0]               taps,
  input  logic [NUM_TAPS-1:0][COEF_W-1:0]   act_mag,
  input  logic [NUM_TAPS-1:0]               act_neg,
  output logic signed [OUT_W-1:0]           code
);

  localparam int HI_I = (1 << (OUT_W - 1)) - 1;
  localparam int LO_I = -(1 << (OUT_W - 1));
  localparam logic signed [CMP_W-1:0] SAT_HI = CMP_W'(HI_I);
  localparam logic signed [CMP_W-1:0] SAT_LO = CMP_W'(LO_I);

  logic signed [SUM_W-1:0] term [NUM_TAPS];
  logic signed [SUM_W-1:0] acc;
  logic signed [CMP_W-1:0] wide;

  // A data 1 maps to +1; a negative coefficient flips the product.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_term
    logic signed [SUM_W-1:0] mag_s;
    assign mag_s   = $signed(SUM_W'(act_mag[g]));
    assign term[g] = (taps[g] ^ act_neg[g]) ? mag_s : -mag_s;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      acc = acc + term[i];
    end
  end

  assign wide = CMP_W'(acc);

  always_comb begin
    if (wide > SAT_HI) begin
      code = OUT_W'(SAT_HI);
    end else if (wide < SAT_LO) begin
      code = OUT_W'(SAT_LO);
    end else begin
      code = OUT_W'(wide);
    end
  end

endmodule

// File: rtl/tx_fir_emph.sv
module tx_fir_emph
  import tx_fir_pkg::*;
#(
  parameter int COEF_W = 5,
  parameter int OUT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bit_in,
  input  logic                     cfg_we,
  input  logic [TAP_SEL_W-1:0]     cfg_sel,
  input  logic [COEF_W-1:0]        cfg_mag,
  input  logic                     cfg_neg,
  input  logic                     cfg_commit,
  output logic signed [OUT_W-1:0]  drv_code,
  output logic                     drv_valid
);

  logic [NUM_TAPS-1:0]             taps;
  logic                            filled;
  logic [NUM_TAPS-1:0][COEF_W-1:0] act_mag;
  logic [NUM_TAPS-1:0]             act_neg;
  logic signed [OUT_W-1:0]         sum_code;
  logic                            main_bit;

  tx_fir_tapline #(
    .DEPTH (NUM_TAPS)
  ) u_tapline (
    .clk    (clk),
    .rst    (rst),
    .bit_in (bit_in),
    .taps   (taps),
    .filled (filled)
  );

  tx_fir_coef_bank #(
    .COEF_W (COEF_W)
  ) u_coef (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .mag     (cfg_mag),
    .neg     (cfg_neg),
    .commit  (cfg_commit),
    .act_mag (act_mag),
    .act_neg (act_neg)
  );

  tx_fir_sum #(
    .COEF_W (COEF_W),
    .OUT_W  (OUT_W)
  ) u_sum (
    .taps    (taps),
    .act_mag (act_mag),
    .act_neg (act_neg),
    .code    (sum_code)
  );

  assign main_bit = taps[int'(TAP_MAIN)];

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_code  <= '0;
      drv_valid <= 1'b0;
    end else begin
      drv_code  <= sum_code;
      drv_valid <= filled;
    end
  end

endmodule

// File: rtl/tx_fir_chk.sv
module tx_fir_chk #(
  parameter int COEF_W     = 5,
  parameter int OUT_W      = 8,
  parameter int FILL_EDGES = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_commit,
  input logic                    main_bit,
  input logic [3:0][COEF_W-1:0]  act_mag,
  input logic [3:0]              act_neg,
  input logic signed [OUT_W-1:0] drv_code,
  input logic                    drv_valid
);

  localparam int CNT_W = $clog2(FILL_EDGES + 1);
  logic [CNT_W-1:0] edges_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      edges_q <= '0;
    end else if (edges_q != CNT_W'(FILL_EDGES)) begin
      edges_q <= edges_q + 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (drv_code == '0 && !drv_valid && act_mag == '0 && act_neg[0] == 1'b0 && act_neg[3] == 1'b0)); // R1

  AST_VALID_FILL: assert property (@(posedge clk) disable iff (rst)
    drv_valid == (edges_q == CNT_W'(FILL_EDGES))); // R9

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    drv_valid |=> drv_valid); // R9

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_commit)) |-> ($stable(act_mag) && $stable(act_neg))); // R5

  AST_MAIN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (act_mag[0] == '0 && act_mag[2] == '0 && act_mag[3] == '0) |=>
      ($signed(drv_code) == ($past(main_bit) ? $signed({1'b0, $past(act_mag[1])})
                                             : -$signed({1'b0, $past(act_mag[1])})))); // R10

endmodule

bind tx_fir_emph tx_fir_chk #(
  .COEF_W (COEF_W),
  .OUT_W  (OUT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_commit (cfg_commit),
  .main_bit   (main_bit),
  .act_mag    (act_mag),
  .act_neg    (act_neg),
  .drv_code   (drv_code),
  .drv_valid  (drv_valid)
);

// File: tb/tb_tx_fir_emph.sv
`timescale 1ns/1ps
module tb_tx_fir_emph;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [4:0] cfg_mag = '0;
  logic cfg_neg = 1'b0;
  logic cfg_commit = 1'b0;
  logic signed [7:0] drv_code;
  logic drv_valid;
  logic signed [5:0] nar_code;
  logic nar_valid;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  tx_fir_emph #(.COEF_W(5), .OUT_W(8)) dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_mag(cfg_mag), .cfg_neg(cfg_neg), .cfg_commit(cfg_commit),
    .drv_code(drv_code), .drv_valid(drv_valid)
  );

  tx_fir_emph #(.COEF_W(5), .OUT_W(6)) dut_narrow (
    .clk(clk), .rst(rst), .bit_in(bit_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_mag(cfg_mag), .cfg_neg(cfg_neg), .cfg_commit(cfg_commit),
    .drv_code(nar_code), .drv_valid(nar_valid)
  );

  typedef struct packed {
    logic              pre_neg;
    logic [4:0]        pre;
    logic [4:0]        main;
    logic [4:0]        post1;
    logic              post2_neg;
    logic [4:0]        post2;
    logic [3:0]        bits;   // {pre, main, post1, post2}
    logic signed [7:0] exp_w;
    logic signed [5:0] exp_n;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 5'd0,  5'd20, 5'd0,  1'b0, 5'd0,  4'b1100,  8'sd20,   6'sd20},
    '{1'b0, 5'd0,  5'd20, 5'd0,  1'b0, 5'd0,  4'b1000, -8'sd20,  -6'sd20},
    '{1'b0, 5'd0,  5'd24, 5'd8,  1'b0, 5'd0,  4'b1110,  8'sd16,   6'sd16},
    '{1'b0, 5'd0,  5'd24, 5'd8,  1'b0, 5'd0,  4'b1100,  8'sd32,   6'sd31},
    '{1'b1, 5'd4,  5'd20, 5'd6,  1'b0, 5'd2,  4'b1010, -8'sd32,  -6'sd32},
    '{1'b1, 5'd4,  5'd20, 5'd6,  1'b0, 5'd2,  4'b0101,  8'sd32,   6'sd31},
    '{1'b0, 5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 4'b1100,  8'sd124,  6'sd31},
    '{1'b0, 5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 4'b0011, -8'sd124, -6'sd32}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [4:0] mag, input logic neg);
    cfg_we = 1'b1; cfg_sel = sel; cfg_mag = mag; cfg_neg = neg;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic commit();
    cfg_commit = 1'b1;
    tick();
    cfg_commit = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    check("R1 code in reset", int'(drv_code), 0);
    check("R1 valid in reset", int'(drv_valid), 0);

    // R9: valid after fill
    rst = 1'b0; bit_in = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      check("R9 valid low while filling", int'(drv_valid), 0);
    end
    tick();
    check("R9 valid high at fifth edge", int'(drv_valid), 1);
    check("R1 coefficients cleared", int'(drv_code), 0);

    // Table walk: R2, R4, R11, R8
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, VECS[v].pre,   VECS[v].pre_neg);
      wr(2'd1, VECS[v].main,  1'b0);
      wr(2'd2, VECS[v].post1, 1'b0);
      wr(2'd3, VECS[v].post2, VECS[v].post2_neg);
      commit();
      bit_in = VECS[v].bits[0]; tick();
      bit_in = VECS[v].bits[1]; tick();
      bit_in = VECS[v].bits[2]; tick();
      bit_in = VECS[v].bits[3]; tick();
      bit_in = 1'b0; tick();
      check("R2 R4 R11 tap sum", int'(drv_code), int'(VECS[v].exp_w));
      check("R8 narrow saturation", int'(nar_code), int'(VECS[v].exp_n));
    end

    // R5 / R6: staged coefficients and commit edge
    wr(2'd0, 5'd0, 1'b0); wr(2'd2, 5'd0, 1'b0); wr(2'd3, 5'd0, 1'b0);
    wr(2'd1, 5'd20, 1'b0);
    commit();
    bit_in = 1'b1;
    tick(); tick(); tick();
    check("R10 main only", int'(drv_code), 20);
    wr(2'd1, 5'd10, 1'b0);
    check("R5 write not applied", int'(drv_code), 20);
    tick(); tick();
    check("R5 still old set", int'(drv_code), 20);
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    check("R6 commit edge uses old set", int'(drv_code), 20);
    tick();
    check("R6 next edge uses new set", int'(drv_code), 10);

    // R7: write and commit on the same edge
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_mag = 5'd5; cfg_neg = 1'b0; cfg_commit = 1'b1;
    tick();
    cfg_we = 1'b0; cfg_commit = 1'b0;
    tick();
    check("R7 same-edge write excluded", int'(drv_code), 10);
    commit();
    tick();
    check("R7 write applied by next commit", int'(drv_code), 5);

    // R3: sign bit ignored on main and first post tap
    wr(2'd1, 5'd12, 1'b1);
    commit(); tick();
    check("R3 main sign ignored", int'(drv_code), 12);
    wr(2'd2, 5'd4, 1'b0);
    commit(); tick();
    check("R3 post1 always subtracts", int'(drv_code), 8);

    // R10: main-only tracking on a mixed pattern
    wr(2'd2, 5'd0, 1'b0);
    commit();
    begin
      logic [7:0] pat;
      pat = 8'b1011_0010;
      for (int i = 0; i < 8; i++) begin
        bit_in = pat[i];
        tick();
        if (i >= 2) check("R10 code follows main bit", int'(drv_code), pat[i-2] ? 12 : -12);
      end
    end

    // R1 / R9: reset in mid-stream
    rst = 1'b1; tick();
    check("R1 code cleared by reset", int'(drv_code), 0);
    check("R9 valid cleared by reset", int'(drv_valid), 0);
    rst = 1'b0; bit_in = 1'b1; tick();
    check("R9 valid low after reset", int'(drv_valid), 0);
    tick(); tick(); tick(); tick();
    check("R1 active coefficients cleared", int'(drv_code), 0);
    check("R9 valid after refill", int'(drv_valid), 1);

    finish_run();
  end

endmodule